// File: doc/BRIEF.md
# External Bus Handover Controller

This block hands a processor's external memory bus to an outside master and takes it back. The master asks for the bus by pulling an active-low request line. The line is asynchronous to the internal clock, so it is synchronized first. Once the request is seen, the controller blocks new internal accesses. It waits until the internal access-busy flag is clear and every active-low memory enable strobe is high. It then releases the address, data and enable drivers by lowering a single output-enable. After a fixed number of clocks it pulls the active-low acknowledge.

While the bus is granted, the controller holds the grant for a minimum window. That window is the largest of three 4-bit access-time fields from a control word. When the request is withdrawn after that window, a fixed release delay runs. At the end of it the acknowledge returns high, the drivers are enabled again and internal accesses are unblocked, all on the same edge. A request withdrawn while the controller is still waiting for pending activity is dropped without touching the bus.

Top module: `ebus_handover`

## Requirements
- R1: After reset, `ack_n` is 1, `bus_oe` is 1 and `acc_block` is 0.
- R2: `req_n` passes a two-flop synchronizer. If `req_n` is first sampled low at edge k while idle, `acc_block` goes high after edge k+2.
- R3: While the controller waits, `bus_oe` stays 1 if `acc_busy` is 1 or any bit of `mem_en_n` is 0. `bus_oe` falls at the first edge, no earlier than k+3, at which `acc_busy` is 0 and `mem_en_n` is all ones.
- R4: `ack_n` falls exactly GRANT_DLY (default 4) edges after `bus_oe` falls. `bus_oe` is 0 whenever `ack_n` is 0.
- R5: The hold window ATIMEMAX is the largest of `atime_cfg[11:8]`, `atime_cfg[7:4]` and `atime_cfg[3:0]`. If `ack_n` fell at edge G, the release phase cannot start before edge G+ATIMEMAX+1.
- R6: The release phase starts at the first edge, no earlier than the R5 limit, at which the synchronized request is inactive. That edge is r+2 when `req_n` is first sampled high at edge r. RELEASE_DLY (default 4) edges later, `ack_n` and `bus_oe` both return to 1 on the same edge.
- R7: `acc_block` is 1 whenever `bus_oe` is 0. It falls on the same edge that `bus_oe` returns to 1.
- R8: If the synchronized request goes inactive while the controller still waits for pending activity, the controller returns to idle. `acc_block` falls at edge r+2, and neither `bus_oe` nor `ack_n` changes.
- R9: Once `bus_oe` has fallen, withdrawing the request does not abort the handover. `ack_n` still falls per R4, and release then follows R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 1 | Active-low bus request from the outside master, asynchronous |
| acc_busy | input | 1 | High while an internal external-memory access is pending |
| mem_en_n | input | N_EN | Active-low memory enable strobes currently driven |
| atime_cfg | input | N_REGION*FLD_W | Packed per-region access-time fields |
| ack_n | output | 1 | Active-low bus acknowledge, registered |
| bus_oe | output | 1 | Drive enable for address, data and enable pads (0 = high impedance), registered |
| acc_block | output | 1 | Blocks new internal memory accesses, registered |

## Verification
Each result is due a fixed number of edges after its cause. The block goes high 2 edges after the request is first sampled low. The drivers float at the later of 3 edges after that or the edge where busy and strobes are first seen clear. The acknowledge follows the float by 4 edges. Release starts at the later of 2 edges after the request is sampled high or ATIMEMAX+1 edges after the grant, and the restore comes 4 edges after release starts.

A free-running edge counter time-stamps every output transition. The bench reads that counter and drives all inputs on the falling clock edge. It predicts each transition edge from the stimulus alone and compares it with the recorded stamp, so a transition that is off by one cycle is reported.

// File: rtl/ebus_handover.sv
module ebus_handover #(
  parameter int FLD_W       = 4,
  parameter int N_REGION    = 3,
  parameter int N_EN        = 3,
  parameter int GRANT_DLY   = 4,
  parameter int RELEASE_DLY = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_n,
  input  logic                      acc_busy,
  input  logic [N_EN-1:0]           mem_en_n,
  input  logic [N_REGION*FLD_W-1:0] atime_cfg,
  output logic                      ack_n,
  output logic                      bus_oe,
  output logic                      acc_block
);

  localparam int DLY_MAX = (GRANT_DLY > RELEASE_DLY) ? GRANT_DLY : RELEASE_DLY;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  typedef enum logic [2:0] {IDLE, WAIT_PENDING, TRISTATE, GRANTED, RELEASE} st_t;

  st_t              st;
  logic             req_m, req_s;
  logic [CNT_W-1:0] cnt;
  logic [FLD_W-1:0] hold, amax;

  wire quiet = !acc_busy && (&mem_en_n);

  always_comb begin
    amax = '0;
    for (int i = 0; i < N_REGION; i++)
      if (atime_cfg[i*FLD_W +: FLD_W] > amax) amax = atime_cfg[i*FLD_W +: FLD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_m     <= 1'b0;
      req_s     <= 1'b0;
      st        <= IDLE;
      cnt       <= '0;
      hold      <= '0;
      ack_n     <= 1'b1;
      bus_oe    <= 1'b1;
      acc_block <= 1'b0;
    end else begin
      req_m <= !req_n;
      req_s <= req_m;
      case (st)
        IDLE:
          if (req_s) begin
            st        <= WAIT_PENDING;
            acc_block <= 1'b1;
          end
        WAIT_PENDING:
          if (!req_s) begin
            st        <= IDLE;
            acc_block <= 1'b0;
          end else if (quiet) begin
            st     <= TRISTATE;
            bus_oe <= 1'b0;
            cnt    <= '0;
          end
        TRISTATE:
          if (cnt == CNT_W'(GRANT_DLY - 1)) begin
            st    <= GRANTED;
            ack_n <= 1'b0;
            hold  <= amax;
          end else begin
            cnt <= cnt + 1'b1;
          end
        GRANTED:
          if (hold != '0) begin
            hold <= hold - 1'b1;
          end else if (!req_s) begin
            st  <= RELEASE;
            cnt <= '0;
          end
        RELEASE:
          if (cnt == CNT_W'(RELEASE_DLY - 1)) begin
            st        <= IDLE;
            ack_n     <= 1'b1;
            bus_oe    <= 1'b1;
            acc_block <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: st <= IDLE;
      endcase
    end
  end

  // R3
  float_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> $past(quiet));

  // R4
  ack_needs_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !bus_oe);

  // R4
  grant_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> !$past(bus_oe));

  // R6
  joint_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> ($rose(bus_oe) && $fell(acc_block)));

  // R7
  block_covers_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> acc_block);

  // R9
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TRISTATE) |=> (st == TRISTATE || st == GRANTED));

endmodule

// File: tb/ebus_handover_bench.sv
module ebus_handover_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_n = 1'b1;
  logic       acc_busy = 1'b0;
  logic [2:0] mem_en_n = 3'b111;
  logic [11:0] atime_cfg = '0;
  logic       ack_n, bus_oe, acc_block;

  int checks = 0, fails = 0, cyc = 0;
  int t_blk_rise, t_blk_fall, t_oe_fall, t_oe_rise, t_ack_fall, t_ack_rise;
  logic p_blk, p_oe, p_ack;
  bit done = 0;

  ebus_handover u_ebus_handover (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .acc_busy(acc_busy),
    .mem_en_n(mem_en_n), .atime_cfg(atime_cfg),
    .ack_n(ack_n), .bus_oe(bus_oe), .acc_block(acc_block));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // fields: busy[39:32] strobe[31:24] cfg[23:12] req_len[11:4] amax[3:0]
  localparam logic [39:0] VEC [6] = '{
    {8'd0, 8'd0, 12'h000, 8'd20, 4'd0},
    {8'd7, 8'd2, 12'h321, 8'd20, 4'd3},
    {8'd1, 8'd9, 12'h1F2, 8'd12, 4'd15},
    {8'd0, 8'd0, 12'h00A, 8'd3,  4'd10},
    {8'd5, 8'd5, 12'hC40, 8'd40, 4'd12},
    {8'd2, 8'd0, 12'h7E5, 8'd6,  4'd14}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stamps();
    t_blk_rise = -1; t_blk_fall = -1; t_oe_fall = -1;
    t_oe_rise = -1; t_ack_fall = -1; t_ack_rise = -1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_blk && acc_block && t_blk_rise < 0) t_blk_rise = cyc;
      if (p_blk && !acc_block && t_blk_fall < 0) t_blk_fall = cyc;
      if (p_oe && !bus_oe && t_oe_fall < 0) t_oe_fall = cyc;
      if (!p_oe && bus_oe && t_oe_rise < 0) t_oe_rise = cyc;
      if (p_ack && !ack_n && t_ack_fall < 0) t_ack_fall = cyc;
      if (!p_ack && ack_n && t_ack_rise < 0) t_ack_rise = cyc;
    end
    p_blk = acc_block; p_oe = bus_oe; p_ack = ack_n;
  end

  task automatic run_vec(input int busy, input int strb, input logic [11:0] cfg,
                         input int rlen, input int amax);
    int k, c, oe, g, r, s, up;
    @(negedge clk);
    atime_cfg = cfg;
    @(negedge clk);
    clear_stamps();
    k = cyc + 1;
    req_n = 1'b0;
    acc_busy = (busy > 0);
    mem_en_n = (strb > 0) ? 3'b110 : 3'b111;
    for (int j = 1; j <= 300; j++) begin
      @(negedge clk);
      if (j >= busy) acc_busy = 1'b0;
      if (j >= strb) mem_en_n = 3'b111;
      if (j >= rlen) req_n = 1'b1;
      if (t_ack_rise >= 0 && j > rlen + 2) break;
    end
    c  = k + ((busy > strb) ? busy : strb);
    oe = (c > k + 3) ? c : k + 3;
    g  = oe + 4;
    r  = k + rlen;
    s  = (r + 2 > g + amax + 1) ? r + 2 : g + amax + 1;
    up = s + 4;
    check(t_blk_rise == k + 2, "R2 block rise", t_blk_rise - k, 2);
    check(t_oe_fall == oe, "R3 float edge", t_oe_fall - k, oe - k);
    check(t_ack_fall == g, "R4 ack fall", t_ack_fall - k, g - k);
    check(t_ack_rise == up, (rlen < 6) ? "R9 R5 ack rise" : "R5 ack rise", t_ack_rise - k, up - k);
    check(t_oe_rise == up, "R6 drive restore", t_oe_rise - k, up - k);
    check(t_blk_fall == up, "R7 block fall", t_blk_fall - k, up - k);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(ack_n === 1'b1, "R1 ack_n", int'(ack_n), 1);
    check(bus_oe === 1'b1, "R1 bus_oe", int'(bus_oe), 1);
    check(acc_block === 1'b0, "R1 acc_block", int'(acc_block), 0);

    foreach (VEC[i])
      run_vec(int'(VEC[i][39:32]), int'(VEC[i][31:24]), VEC[i][23:12],
              int'(VEC[i][11:4]), int'(VEC[i][3:0]));

    begin : abort_case // R8
      int k;
      @(negedge clk);
      clear_stamps();
      k = cyc + 1;
      req_n = 1'b0;
      acc_busy = 1'b1;
      for (int j = 1; j <= 20; j++) begin
        @(negedge clk);
        if (j >= 6) req_n = 1'b1;
      end
      check(t_blk_rise == k + 2, "R8 block rise", t_blk_rise - k, 2);
      check(t_blk_fall == k + 8, "R8 block drop", t_blk_fall - k, 8);
      check(t_oe_fall == -1, "R8 no float", t_oe_fall, -1);
      check(t_ack_fall == -1, "R8 no ack", t_ack_fall, -1);
      acc_busy = 1'b0;
      repeat (3) @(negedge clk);
    end

    begin : strobe_hold // R3
      int k;
      clear_stamps();
      k = cyc + 1;
      req_n = 1'b0;
      mem_en_n = 3'b011;
      for (int j = 1; j <= 12; j++) @(negedge clk);
      check(bus_oe === 1'b1 && ack_n === 1'b1, "R3 held by strobe", int'(bus_oe), 1);
      mem_en_n = 3'b111;
      for (int j = 1; j <= 6; j++) @(negedge clk);
      check(t_oe_fall == k + 12, "R3 float after strobe", t_oe_fall - k, 12);
      req_n = 1'b1;
      for (int j = 1; j <= 20; j++) @(negedge clk);
      check(ack_n === 1'b1 && bus_oe === 1'b1, "R6 restored", int'(ack_n), 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule